// File: doc/BRIEF.md
# Channel Offset and Gain Correction

This block trims raw filter results with one of three offset/gain coefficient pairs. It takes each unsigned 24-bit filter result and subtracts the chosen offset coefficient. A negative difference becomes zero. The block then multiplies the difference by the chosen gain coefficient. Gain is an unsigned fixed-point value in which 0x800000 stands for a factor of one. The scaled value is clipped to 24 bits and stored in an output data register. A one-cycle strobe marks each new result.

A 3-bit channel field selects the active pair, which is pair index `chan_sel mod 3`. The same pair is used for correction, for register-port access and for calibration capture. The measurement logic outside the block reports the end of a calibration with `cal_done`, a 3-bit mode code and the measured value. The block stores that value in the selected offset or gain register, depending on the mode code.

Top module: `cal_corrector`

## Requirements
- R1: After reset, every offset register reads 0, every gain register reads 0x800000, `res_valid` is 0 and `res_data` is 0.
- R2: The pair index is `chan_sel mod 3`. Channel codes 3..7 therefore reach pairs 0, 1, 2, 0, 1. This index governs correction, register access and calibration capture.
- R3: Register address 3'b101 reads and writes the offset register of the selected pair. Address 3'b110 does the same for its gain register. A write to any other address changes no coefficient, and a read of any other address returns 0. Reads are combinational. A write takes effect at the clock edge where `reg_we` is high.
- R4: The result is `((filt_data - offset) * gain) >> 23`, so the offset is subtracted before the gain is applied.
- R5: If `filt_data` is less than the offset, the result is 0.
- R6: If the scaled value exceeds 0xFFFFFF, the result is 0xFFFFFF.
- R7: `res_valid` is high for exactly the cycle after each cycle in which `filt_valid` is high. `res_data` then holds the new result. `res_data` keeps its value when `filt_valid` is low.
- R8: `cal_done` with mode code 3'b100 or 3'b110 loads `cal_meas` into the offset register of the selected pair.
- R9: `cal_done` with mode code 3'b101 or 3'b111 loads `cal_meas` into the gain register of the selected pair.
- R10: `cal_done` with a mode code whose top bit is 0 changes no coefficient.
- R11: If a calibration capture and a register-port write target the same register in one cycle, the captured measurement is stored.
- R12: Each of the six coefficient registers changes only through an access or capture that selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 3 | Channel field; selects pair `chan_sel mod 3` |
| cal_done | input | 1 | Calibration finished, one-cycle pulse |
| cal_mode | input | 3 | Mode code of the finished calibration |
| cal_meas | input | 24 | Measured coefficient to capture |
| reg_we | input | 1 | Register-port write enable |
| reg_addr | input | 3 | Register-port address |
| reg_wdata | input | 24 | Register-port write data |
| reg_rdata | output | 24 | Register-port read data |
| filt_valid | input | 1 | Filter result present |
| filt_data | input | 24 | Unsigned filter result |
| res_valid | output | 1 | Corrected result strobe |
| res_data | output | 24 | Corrected data register |

## Verification
One pattern uses a nonzero offset together with a gain below one. Applying the offset first gives a different result from applying the gain first, so this pattern checks the order of operations. Other patterns place the input below the offset, raise it to full scale with a gain near two, and leave the unity gain untouched. These separate the clamp at zero, the clip at full scale and plain subtraction. Distinct values are written to every pair and then read back through wrapped channel codes. Capture pulses are sent with every mode code, including one that collides with a port write. Together these confirm the pair decode, that the pairs stay independent, and which register each mode code loads.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam logic [2:0] ADDR_OFS  = 3'b101;
  localparam logic [2:0] ADDR_GAIN = 3'b110;
  // mode code: bit 2 marks a calibration, bit 0 picks gain (1) or offset (0)
  localparam int MODE_CAL_BIT  = 2;
  localparam int MODE_GAIN_BIT = 0;
endpackage

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
  import cal_pkg::*;
#(
  parameter int DW    = 24,
  parameter int NPAIR = 3,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] chan_sel,
  input  logic          cal_done,
  input  logic [2:0]    cal_mode,
  input  logic [DW-1:0] cal_meas,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] ofs_sel,
  output logic [DW-1:0] gain_sel
);
  localparam int IW = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam logic [DW-1:0] GAIN_ONE = DW'(1) << (DW - 1);

  logic [IW-1:0] idx;
  logic cap_ofs, cap_gain, wr_ofs, wr_gain;
  logic [NPAIR-1:0][DW-1:0] ofs_q, gain_q;

  always_comb begin
    idx      = IW'(chan_sel % CW'(NPAIR));
    cap_ofs  = cal_done && cal_mode[MODE_CAL_BIT] && !cal_mode[MODE_GAIN_BIT];
    cap_gain = cal_done && cal_mode[MODE_CAL_BIT] &&  cal_mode[MODE_GAIN_BIT];
    wr_ofs   = reg_we && (reg_addr == ADDR_OFS);
    wr_gain  = reg_we && (reg_addr == ADDR_GAIN);
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic          hit, ofs_en, gain_en;
    logic [DW-1:0] ofs_d, gain_d;

    always_comb begin
      hit     = (idx == IW'(g));
      ofs_en  = hit && (cap_ofs || wr_ofs);
      gain_en = hit && (cap_gain || wr_gain);
      ofs_d   = cap_ofs  ? cal_meas : reg_wdata;
      gain_d  = cap_gain ? cal_meas : reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ofs_q[g]  <= '0;
        gain_q[g] <= GAIN_ONE;
      end else begin
        if (ofs_en)  ofs_q[g]  <= ofs_d;
        if (gain_en) gain_q[g] <= gain_d;
      end
    end
  end

  assign ofs_sel  = ofs_q[idx];
  assign gain_sel = gain_q[idx];

  // R8, R11: offset capture wins over a port write
  a_r8_ofs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done && cal_mode[2] && !cal_mode[0] |=> ofs_q[$past(idx)] == $past(cal_meas));
  // R9
  a_r9_gain_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done && cal_mode[2] && cal_mode[0] |=> gain_q[$past(idx)] == $past(cal_meas));
  // R10
  a_r10_no_cal: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we && !(cal_done && cal_mode[2]) |=> $stable(ofs_q) && $stable(gain_q));
endmodule

// File: rtl/cal_apply.sv
module cal_apply #(
  parameter int DW   = 24,
  parameter int FRAC = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          filt_valid,
  input  logic [DW-1:0] filt_data,
  input  logic [DW-1:0] ofs,
  input  logic [DW-1:0] gain,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  localparam int PW = 2 * DW;

  logic [DW:0]   diff;
  logic [DW-1:0] mag;
  logic [PW-1:0] prod, scaled;
  logic [DW-1:0] res_d;
  logic          vld_q;
  logic [DW-1:0] res_q;

  always_comb begin
    diff   = {1'b0, filt_data} - {1'b0, ofs};
    mag    = diff[DW] ? '0 : diff[DW-1:0];
    prod   = {{DW{1'b0}}, mag} * {{DW{1'b0}}, gain};
    scaled = prod >> FRAC;
    res_d  = (|scaled[PW-1:DW]) ? '1 : scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= filt_valid;
      if (filt_valid) res_q <= res_d;
    end
  end

  assign res_valid = vld_q;
  assign res_data  = res_q;

  a_r7_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    filt_valid |=> res_valid);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_valid |=> !res_valid && $stable(res_data));
  a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    filt_valid && (filt_data <= ofs) |=> res_data == '0);
  a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    filt_valid && (&filt_data) && (ofs == '0) && gain[DW-1] && (|gain[DW-2:0]) |=> &res_data);
endmodule

// File: rtl/cal_corrector.sv
module cal_corrector
  import cal_pkg::*;
#(
  parameter int DW    = 24,
  parameter int NPAIR = 3,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] chan_sel,
  input  logic          cal_done,
  input  logic [2:0]    cal_mode,
  input  logic [DW-1:0] cal_meas,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          filt_valid,
  input  logic [DW-1:0] filt_data,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  logic [DW-1:0] ofs_sel, gain_sel;

  cal_coef_bank #(.DW(DW), .NPAIR(NPAIR), .CW(CW)) bank_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel),
    .cal_done(cal_done), .cal_mode(cal_mode), .cal_meas(cal_meas),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ofs_sel(ofs_sel), .gain_sel(gain_sel)
  );

  cal_apply #(.DW(DW), .FRAC(DW - 1)) apply_i (
    .clk(clk), .rst_n(rst_n), .filt_valid(filt_valid), .filt_data(filt_data),
    .ofs(ofs_sel), .gain(gain_sel), .res_valid(res_valid), .res_data(res_data)
  );

  // R3: read mux
  always_comb begin
    if (reg_addr == ADDR_OFS)       reg_rdata = ofs_sel;
    else if (reg_addr == ADDR_GAIN) reg_rdata = gain_sel;
    else                            reg_rdata = '0;
  end

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == ADDR_GAIN) && !(cal_done && cal_mode[2])
    |=> ($past(chan_sel) != chan_sel) || (gain_sel == $past(reg_wdata)));
endmodule

// File: tb/cal_corrector_tb_top.sv
module cal_corrector_tb_top;
  logic clk, rst_n;
  logic [2:0] chan_sel, cal_mode, reg_addr;
  logic cal_done, reg_we, filt_valid, res_valid;
  logic [23:0] cal_meas, reg_wdata, reg_rdata, filt_data, res_data;
  int checks = 0, errors = 0;

  cal_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .cal_done(cal_done),
    .cal_mode(cal_mode), .cal_meas(cal_meas), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .filt_valid(filt_valid), .filt_data(filt_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [23:0] f, o, g);
    longint d, p;
    d = longint'(f) - longint'(o);
    if (d < 0) return 24'h0;
    p = (d * longint'(g)) >>> 23;
    if (p > 64'hFFFFFF) return 24'hFFFFFF;
    return p[23:0];
  endfunction

  task automatic wr(input logic [2:0] ch, a, input logic [23:0] d);
    @(negedge clk);
    chan_sel = ch; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ch, a, output logic [23:0] d);
    chan_sel = ch; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] ch, a, input logic [23:0] exp);
    logic [23:0] v;
    rd(ch, a, v);
    chk(req, v, exp);
  endtask

  task automatic conv(input string req, input logic [2:0] ch, input logic [23:0] f, exp);
    logic [23:0] held;
    @(negedge clk);
    chan_sel = ch; filt_data = f; filt_valid = 1'b1;
    @(negedge clk);
    filt_valid = 1'b0; filt_data = ~f;
    chk({req, " R7 strobe"}, {23'd0, res_valid}, 24'd1);
    chk(req, res_data, exp);
    held = res_data;
    @(negedge clk);
    chk("R7 strobe drop", {23'd0, res_valid}, 24'd0);
    chk("R7 hold", res_data, held);
  endtask

  task automatic cal(input logic [2:0] ch, mode, input logic [23:0] m);
    @(negedge clk);
    chan_sel = ch; cal_mode = mode; cal_meas = m; cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
  endtask

  task automatic t_reset;
    for (int p = 0; p < 3; p++) begin
      rd_chk("R1 offset", 3'(p), 3'b101, 24'h0);
      rd_chk("R1 gain", 3'(p), 3'b110, 24'h800000);
    end
    chk("R1 valid", {23'd0, res_valid}, 24'd0);
    chk("R1 data", res_data, 24'd0);
  endtask

  task automatic t_regs;
    for (int p = 0; p < 3; p++) begin
      wr(3'(p), 3'b101, 24'h010000 * (p + 1));
      wr(3'(p), 3'b110, 24'h400000 + 24'h111 * p);
    end
    for (int p = 0; p < 3; p++) begin
      rd_chk("R3 R12 offset", 3'(p), 3'b101, 24'h010000 * (p + 1));
      rd_chk("R3 R12 gain", 3'(p), 3'b110, 24'h400000 + 24'h111 * p);
    end
    wr(3'd1, 3'b011, 24'hABCDEF);
    rd_chk("R3 other addr read", 3'd1, 3'b011, 24'h0);
    rd_chk("R3 other addr no write ofs", 3'd1, 3'b101, 24'h020000);
    rd_chk("R3 other addr no write gain", 3'd1, 3'b110, 24'h400111);
  endtask

  task automatic t_wrap;
    rd_chk("R2 chan3 to pair0", 3'd3, 3'b101, 24'h010000);
    rd_chk("R2 chan4 to pair1", 3'd4, 3'b101, 24'h020000);
    rd_chk("R2 chan5 to pair2", 3'd5, 3'b101, 24'h030000);
    rd_chk("R2 chan7 to pair1", 3'd7, 3'b110, 24'h400111);
    wr(3'd6, 3'b101, 24'h000777);
    rd_chk("R2 chan6 write pair0", 3'd0, 3'b101, 24'h000777);
    rd_chk("R2 R12 pair1 untouched", 3'd1, 3'b101, 24'h020000);
  endtask

  task automatic t_correct;
    wr(3'd0, 3'b101, 24'h100000);
    wr(3'd0, 3'b110, 24'h400000);
    conv("R4 order", 3'd0, 24'h300000, 24'h100000);
    wr(3'd2, 3'b101, 24'h000123);
    wr(3'd2, 3'b110, 24'h800000);
    conv("R4 unity", 3'd5, 24'h456789, 24'h456666);
    wr(3'd1, 3'b110, 24'hC00000);
    conv("R4 gain 1.5", 3'd1, 24'h220000, model(24'h220000, 24'h020000, 24'hC00000));
    conv("R5 clamp", 3'd1, 24'h010000, 24'h0);
    conv("R5 equal", 3'd1, 24'h020000, 24'h0);
    wr(3'd1, 3'b101, 24'h0);
    wr(3'd1, 3'b110, 24'hFFFFFF);
    conv("R6 saturate", 3'd1, 24'hFFFFFF, 24'hFFFFFF);
    conv("R6 just below", 3'd1, 24'h7FFFFF, model(24'h7FFFFF, 24'h0, 24'hFFFFFF));
  endtask

  task automatic t_cal;
    cal(3'd2, 3'b100, 24'h00AAAA);
    rd_chk("R8 mode100", 3'd2, 3'b101, 24'h00AAAA);
    cal(3'd2, 3'b110, 24'h00BBBB);
    rd_chk("R8 mode110", 3'd2, 3'b101, 24'h00BBBB);
    rd_chk("R12 gain kept", 3'd2, 3'b110, 24'h800000);
    cal(3'd4, 3'b101, 24'h7A0000);
    rd_chk("R9 mode101", 3'd1, 3'b110, 24'h7A0000);
    cal(3'd4, 3'b111, 24'h7B0000);
    rd_chk("R9 mode111", 3'd1, 3'b110, 24'h7B0000);
    for (int m = 0; m < 4; m++) begin
      cal(3'd2, 3'(m), 24'h123456);
      rd_chk("R10 ofs", 3'd2, 3'b101, 24'h00BBBB);
      rd_chk("R10 gain", 3'd2, 3'b110, 24'h800000);
    end
    @(negedge clk);
    chan_sel = 3'd0; cal_mode = 3'b100; cal_meas = 24'h0C0C0C; cal_done = 1'b1;
    reg_we = 1'b1; reg_addr = 3'b101; reg_wdata = 24'h0D0D0D;
    @(negedge clk);
    cal_done = 1'b0; reg_we = 1'b0;
    rd_chk("R11 capture wins", 3'd0, 3'b101, 24'h0C0C0C);
    conv("R4 after cal", 3'd0, 24'h1C0C0C, 24'h080000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chan_sel = '0; cal_mode = '0; cal_meas = '0; cal_done = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; filt_valid = 1'b0; filt_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_wrap();
    t_correct();
    t_cal();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule